// File: doc/BRIEF.md
# Frame Preemption Partner Verification Controller

This block runs the handshake that confirms both ends of a link support frame preemption. Only after that handshake succeeds does it turn on preemption in the transmit direction. It gets configuration levels (express/preemptible MAC receive side enabled, transmit preemption wanted, handshake wanted), the link state, an interval in milliseconds and a one-cycle millisecond tick. It also gets single-cycle event pulses from the packet engine: verify received, response received, and own verify transmitted. In return it issues single-cycle requests to send a verify or a response packet. It also drives the preemption enable, the preemption event interrupt enable and a 3-bit status code.

A handshake starts when the link comes up with the receive side enabled, or when `cfg_apply` is pulsed while the link is up. The status becomes INITIAL, the retry budget reloads to RETRIES (3), and, if all three enables are set, a verify request goes out at once. After that the interval timer fires every `verify_ms` ticks. While INITIAL or VERIFYING, each firing sends one more verify until the budget is spent, and the next firing moves to FAILED. Confirmation of the own verify leads to VERIFYING, and the partner's response then leads to SUCCEEDED. The next firing after that turns preemption and the event interrupt on. With the handshake switched off, an apply drives the enables straight from the configuration.

States and transitions: DISABLED (reset) → INITIAL on handshake start. INITIAL/VERIFYING → VERIFYING on own verify confirmed. VERIFYING → SUCCEEDED on partner response. INITIAL/VERIFYING → FAILED on timer firing with no retries left. Any → INITIAL on a new handshake start.

Top module: `mm_verify_fsm`

## Requirements
- R1: After reset `status` is DISABLED, and `preempt_on`, `pmac_irq_en`, `send_verify` and `send_response` are 0. Status codes: DISABLED=0, INITIAL=1, VERIFYING=2, SUCCEEDED=3, FAILED=4.
- R2: While `pmac_en` is 1, an `rx_verify` pulse gives a one-cycle `send_response` pulse in the next cycle, whatever the status.
- R3: With `pmac_en` set, a `tx_verify_done` pulse moves the status to VERIFYING unless it is SUCCEEDED, where it stays.
- R4: With `pmac_en` set, an `rx_response` pulse moves VERIFYING to SUCCEEDED. In INITIAL, SUCCEEDED or FAILED the status is unchanged.
- R5: A handshake start (link rise with `pmac_en`, or `cfg_apply` while the link is up and `verify_en` set) sets status INITIAL and reloads the budget. If `pmac_en` and `tx_preempt_en` are both set, `send_verify` pulses two cycles after the start input is driven.
- R6: Later verifies come `verify_ms` ticks apart. No more than three verifies go out per handshake, and the firing after the third moves the status to FAILED with no verify.
- R7: In SUCCEEDED, the next timer firing sets `preempt_on` and `pmac_irq_en`. Neither is set by the response itself.
- R8: With `verify_en` clear, `cfg_apply` (link up) sets `preempt_on` to `tx_preempt_en` and `pmac_irq_en` to `pmac_en`. It sends no verify and leaves the status unchanged.
- R9: A link fall clears `preempt_on` and `pmac_irq_en` and stops the timer, so no further verify is sent.
- R10: A link rise with `pmac_en` sets `pmac_irq_en`, clears `preempt_on` and restarts the handshake as in R5. A link rise without `pmac_en` leaves the status unchanged and both enables at 0.
- R11: While `pmac_en` is 0, `rx_verify`, `rx_response` and `tx_verify_done` have no effect on the status or on `send_response`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pmac_en | input | 1 | Preemptible receive side enabled |
| tx_preempt_en | input | 1 | Transmit preemption wanted |
| verify_en | input | 1 | Partner handshake wanted |
| cfg_apply | input | 1 | Pulse: apply configuration |
| link_up | input | 1 | Link state level |
| verify_ms | input | IVW (8) | Interval between verify attempts, in ticks |
| ms_tick | input | 1 | One-cycle millisecond tick |
| rx_verify | input | 1 | Pulse: partner verify packet received |
| rx_response | input | 1 | Pulse: partner response packet received |
| tx_verify_done | input | 1 | Pulse: own verify packet transmitted |
| send_verify | output | 1 | Pulse: request a verify packet |
| send_response | output | 1 | Pulse: request a response packet |
| preempt_on | output | 1 | Transmit preemption enable |
| pmac_irq_en | output | 1 | Preemption event interrupt enable |
| status | output | 3 | Handshake status code |

## Verification
The properties assume a few things about the inputs. Event pulses, `cfg_apply` and link edges do not land in the same cycle as one another. The enable levels and `verify_ms` stay steady across an apply or link rise. `verify_ms` is non-zero whenever the spacing between verify pulses is checked. The stimulus keeps to these assumptions. It changes configuration only between operations, drives one pulse at a time with idle cycles around it, and uses an interval of 3 ticks with ticks spaced several cycles apart.

// File: rtl/mm_verify_pkg.sv
package mm_verify_pkg;
    typedef enum logic [2:0] {
        MM_OFF       = 3'd0,
        MM_INIT      = 3'd1,
        MM_VERIFYING = 3'd2,
        MM_DONE      = 3'd3,
        MM_FAILED    = 3'd4
    } mm_status_e;
endpackage

// File: rtl/mm_level_edge.sv
module mm_level_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic level_q,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;
endmodule

// File: rtl/mm_interval_timer.sv
module mm_interval_timer #(
    parameter int IVW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire_now,
    input  logic           reload,
    input  logic           halt,
    input  logic [IVW-1:0] ival,
    input  logic           tick,
    output logic           expire
);
    logic           armed;
    logic [IVW-1:0] cnt;

    assign expire = armed && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (halt) begin
            armed <= 1'b0;
        end else if (fire_now) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (reload) begin
            armed <= 1'b1;
            cnt   <= ival;
        end else if (expire) begin
            armed <= 1'b0;
        end else if (armed && tick) begin
            cnt   <= cnt - IVW'(1);
        end
    end
endmodule

// File: rtl/mm_verify_fsm.sv
module mm_verify_fsm
    import mm_verify_pkg::*;
#(
    parameter int IVW     = 8,
    parameter int RETRIES = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pmac_en,
    input  logic           tx_preempt_en,
    input  logic           verify_en,
    input  logic           cfg_apply,
    input  logic           link_up,
    input  logic [IVW-1:0] verify_ms,
    input  logic           ms_tick,
    input  logic           rx_verify,
    input  logic           rx_response,
    input  logic           tx_verify_done,
    output logic           send_verify,
    output logic           send_response,
    output logic           preempt_on,
    output logic           pmac_irq_en,
    output logic [2:0]     status
);
    localparam int RW = $clog2(RETRIES + 1);

    mm_status_e st, st_n, st_ev;
    logic [RW-1:0] ret, ret_n;
    logic pe_n, ie_n, sv_n, sr_n;
    logic t_now, t_reload, t_halt, t_expire;
    logic link_q, link_rise, link_fall;

    mm_level_edge u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (link_up),
        .level_q (link_q),
        .rise    (link_rise),
        .fall    (link_fall)
    );

    mm_interval_timer #(.IVW(IVW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_now (t_now),
        .reload   (t_reload),
        .halt     (t_halt),
        .ival     (verify_ms),
        .tick     (ms_tick),
        .expire   (t_expire)
    );

    // Status after the packet events of this cycle
    always_comb begin
        st_ev = st;
        if (pmac_en) begin
            if (tx_verify_done && st != MM_DONE) st_ev = MM_VERIFYING;
            if (rx_response && st_ev == MM_VERIFYING) st_ev = MM_DONE;
        end
    end

    // Next-state and output decisions
    always_comb begin
        st_n     = st;
        ret_n    = ret;
        pe_n     = preempt_on;
        ie_n     = pmac_irq_en;
        sv_n     = 1'b0;
        sr_n     = pmac_en & rx_verify;
        t_now    = 1'b0;
        t_reload = 1'b0;
        t_halt   = 1'b0;
        if (link_fall || (link_rise && !pmac_en)) begin
            pe_n   = 1'b0;
            ie_n   = 1'b0;
            t_halt = 1'b1;
        end else if (link_rise || (cfg_apply && link_up)) begin
            if (link_rise) begin
                pe_n = 1'b0;
                ie_n = 1'b1;
            end
            if (!verify_en) begin
                pe_n   = tx_preempt_en;
                ie_n   = pmac_en;
                t_halt = 1'b1;
            end else begin
                st_n  = MM_INIT;
                ret_n = RW'(RETRIES);
                if (pmac_en && tx_preempt_en) t_now  = 1'b1;
                else                          t_halt = 1'b1;
            end
        end else begin
            st_n = st_ev;
            if (t_expire) begin
                unique case (st_ev)
                    MM_INIT, MM_VERIFYING: begin
                        if (ret != '0) begin
                            sv_n     = 1'b1;
                            t_reload = 1'b1;
                            ret_n    = ret - RW'(1);
                        end else begin
                            st_n = MM_FAILED;
                        end
                    end
                    MM_DONE: begin
                        pe_n = 1'b1;
                        ie_n = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // State and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= MM_OFF;
            ret           <= RW'(RETRIES);
            preempt_on    <= 1'b0;
            pmac_irq_en   <= 1'b0;
            send_verify   <= 1'b0;
            send_response <= 1'b0;
        end else begin
            st            <= st_n;
            ret           <= ret_n;
            preempt_on    <= pe_n;
            pmac_irq_en   <= ie_n;
            send_verify   <= sv_n;
            send_response <= sr_n;
        end
    end

    assign status = st;
endmodule

// File: rtl/mm_verify_fsm_sva.sv
module mm_verify_fsm_sva #(
    parameter int IVW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pmac_en,
    input logic           verify_en,
    input logic           rx_verify,
    input logic           rx_response,
    input logic [IVW-1:0] verify_ms,
    input logic           link_fall,
    input logic           send_verify,
    input logic           send_response,
    input logic           preempt_on,
    input logic           pmac_irq_en,
    input logic [2:0]     status
);
    always @(posedge clk) begin
        if (rst_n) begin
            p_status_legal_r1: assert (status <= 3'd4)
                else $error("status code out of range");
        end
    end

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pmac_en && rx_verify) |=> send_response);

    p_success_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd3 && $past(status) != 3'd3) |-> ($past(rx_response) && $past(pmac_en)));

    p_verify_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send_verify && verify_ms != '0) |=> !send_verify);

    p_preempt_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(preempt_on) && verify_en) |-> status == 3'd3);

    p_link_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_fall |=> (!preempt_on && !pmac_irq_en));

    p_no_pmac_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pmac_en |=> !send_response);
endmodule

bind mm_verify_fsm mm_verify_fsm_sva #(.IVW(IVW)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .pmac_en       (pmac_en),
    .verify_en     (verify_en),
    .rx_verify     (rx_verify),
    .rx_response   (rx_response),
    .verify_ms     (verify_ms),
    .link_fall     (link_fall),
    .send_verify   (send_verify),
    .send_response (send_response),
    .preempt_on    (preempt_on),
    .pmac_irq_en   (pmac_irq_en),
    .status        (status)
);

// File: tb/mm_verify_fsm_test.sv
module mm_verify_fsm_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pmac_en = 1'b0, tx_preempt_en = 1'b0, verify_en = 1'b0;
    logic cfg_apply = 1'b0, link_up = 1'b0, ms_tick = 1'b0;
    logic rx_verify = 1'b0, rx_response = 1'b0, tx_verify_done = 1'b0;
    logic [7:0] verify_ms = 8'd3;
    logic send_verify, send_response, preempt_on, pmac_irq_en;
    logic [2:0] status;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { bit is_verify; int at; string req; } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mm_verify_fsm uut (
        .clk(clk), .rst_n(rst_n), .pmac_en(pmac_en), .tx_preempt_en(tx_preempt_en),
        .verify_en(verify_en), .cfg_apply(cfg_apply), .link_up(link_up),
        .verify_ms(verify_ms), .ms_tick(ms_tick), .rx_verify(rx_verify),
        .rx_response(rx_response), .tx_verify_done(tx_verify_done),
        .send_verify(send_verify), .send_response(send_response),
        .preempt_on(preempt_on), .pmac_irq_en(pmac_irq_en), .status(status)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(bit v, int at, string req);
        exp_t e;
        e.is_verify = v; e.at = at; e.req = req;
        expq.push_back(e);
    endtask

    // Monitor: pops the expectation for every request pulse seen
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (send_verify) pop_cmp(1'b1);
            if (send_response) pop_cmp(1'b0);
        end
    end

    task automatic pop_cmp(bit v);
        exp_t e;
        checks++;
        if (expq.size() == 0) begin
            failures++;
            $display("FAIL R6 unexpected request actual_kind=%0d at=%0d expected=none", v, cyc);
        end else begin
            e = expq.pop_front();
            if (e.is_verify != v || e.at != cyc) begin
                failures++;
                $display("FAIL %s actual kind=%0d cyc=%0d expected kind=%0d cyc=%0d",
                         e.req, v, cyc, e.is_verify, e.at);
            end
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rxv(bit expect_resp, string req);
        @(negedge clk);
        if (expect_resp) push(1'b0, cyc + 1, req);
        rx_verify = 1'b1;
        @(negedge clk); rx_verify = 1'b0;
        idle(2);
    endtask

    task automatic pulse_rxr();
        @(negedge clk); rx_response = 1'b1;
        @(negedge clk); rx_response = 1'b0;
        idle(2);
    endtask

    task automatic pulse_txd();
        @(negedge clk); tx_verify_done = 1'b1;
        @(negedge clk); tx_verify_done = 1'b0;
        idle(2);
    endtask

    task automatic apply(bit expect_v, string req);
        @(negedge clk);
        if (expect_v) push(1'b1, cyc + 2, req);
        cfg_apply = 1'b1;
        @(negedge clk); cfg_apply = 1'b0;
        idle(4);
    endtask

    task automatic set_link(bit up, bit expect_v, string req);
        @(negedge clk);
        if (expect_v) push(1'b1, cyc + 2, req);
        link_up = up;
        idle(5);
    endtask

    task automatic ticks(int n, bit expect_v, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n - 1 && expect_v) push(1'b1, cyc + 2, req);
            ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
            idle(3);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        check("R1 status", status, 0);
        check("R1 preempt", preempt_on, 0);
        check("R1 irq", pmac_irq_en, 0);
        check("R1 send", send_verify | send_response, 0);

        // R11: events ignored while receive side disabled
        pulse_rxv(1'b0, "R11");
        pulse_txd();
        check("R11 status after tx_verify_done", status, 0);

        // R10 + R5: link rise starts handshake
        pmac_en = 1'b1; tx_preempt_en = 1'b1; verify_en = 1'b1;
        set_link(1'b1, 1'b1, "R5 first verify");
        check("R10 status INITIAL", status, 1);
        check("R10 irq on", pmac_irq_en, 1);
        check("R10 preempt off", preempt_on, 0);

        pulse_rxv(1'b1, "R2 response in INITIAL");
        pulse_rxr();
        check("R4 response ignored in INITIAL", status, 1);
        pulse_txd();
        check("R3 VERIFYING", status, 2);
        pulse_rxv(1'b1, "R2 response in VERIFYING");
        pulse_rxr();
        check("R4 SUCCEEDED", status, 3);
        check("R7 no preempt before firing", preempt_on, 0);

        ticks(3, 1'b0, "R7");
        check("R7 preempt on", preempt_on, 1);
        check("R7 irq on", pmac_irq_en, 1);
        pulse_txd();
        check("R3 stays SUCCEEDED", status, 3);
        pulse_rxr();
        check("R4 stays SUCCEEDED", status, 3);

        // R9: link down
        set_link(1'b0, 1'b0, "R9");
        check("R9 preempt off", preempt_on, 0);
        check("R9 irq off", pmac_irq_en, 0);
        ticks(4, 1'b0, "R9");

        // R6: retry budget and failure
        set_link(1'b1, 1'b1, "R6 verify 1");
        check("R10 restart INITIAL", status, 1);
        ticks(2, 1'b0, "R6");
        ticks(1, 1'b1, "R6 verify 2");
        ticks(3, 1'b1, "R6 verify 3");
        check("R6 still INITIAL", status, 1);
        ticks(3, 1'b0, "R6");
        check("R6 FAILED", status, 4);
        pulse_rxr();
        check("R4 ignored in FAILED", status, 4);
        ticks(3, 1'b0, "R6 no verify after fail");

        // R5: apply restarts from FAILED
        apply(1'b1, "R5 apply verify");
        check("R5 apply INITIAL", status, 1);

        // R8: no handshake
        verify_en = 1'b0;
        apply(1'b0, "R8");
        check("R8 preempt follows tx", preempt_on, 1);
        check("R8 irq follows pmac", pmac_irq_en, 1);
        check("R8 status unchanged", status, 1);
        tx_preempt_en = 1'b0;
        apply(1'b0, "R8");
        check("R8 preempt cleared", preempt_on, 0);
        ticks(4, 1'b0, "R8 timer stopped");

        // R10: link rise without receive side
        set_link(1'b0, 1'b0, "R9");
        pmac_en = 1'b0; verify_en = 1'b1; tx_preempt_en = 1'b1;
        set_link(1'b1, 1'b0, "R10");
        check("R10 no pmac status kept", status, 1);
        check("R10 no pmac preempt", preempt_on, 0);
        check("R10 no pmac irq", pmac_irq_en, 0);
        pulse_rxr();
        check("R11 rx_response ignored", status, 1);

        idle(5);
        check("R6 all expected requests seen", expq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule